// File: doc/BRIEF.md
# I2C Start/Stop Condition Controller

This block keeps the control byte of an I2C interface and, from the flags in that byte, produces START, repeated START and STOP conditions on an open-drain clock/data pair. Software never writes the byte directly. One write port sets every bit that is 1 in its data, and a second write port clears every bit that is 1 in its data. The block watches both bus lines and keeps track of whether another device holds the bus.

When a start is requested and the bus is free, the block takes master mode and produces a START at once. When the bus is busy, it waits for a STOP on the bus, waits one half period more, and then starts. A stop request while the block owns the bus releases the bus. The same request in slave mode gives only a one-cycle internal stop pulse. A single programmable half period, counted in system clocks, times every phase of every condition. Byte transfer, acknowledge handling and address matching are not part of this block. After a START the master holds the clock low and keeps the bus until software asks for a repeated START or a STOP.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00. The bits are: bit 2 acknowledge flag, bit 3 interrupt flag, bit 4 stop request, bit 5 start request, bit 6 enable. A set-port write raises every one of bits 2..6 that is 1 in the data and leaves the others unchanged. Bits 0, 1 and 7 always read 0. The new value shows on `ctrl_q` one clock edge after the write.
- R2: A clear-port write lowers bits 2, 3, 5 and 6 wherever the data holds a 1. Bit 4 cannot be cleared through this port. When the set port and the clear port name the same bit in the same cycle, the clear wins.
- R3: While bit 6 is 0, the stop request stays 0 even when it is written, the bus lines are ignored (`bus_busy` stays 0), the block stays in slave mode and it drives neither line.
- R4: `bus_busy` goes to 1 three clock edges after the lines show SDA falling while SCL is high. It goes to 0 three edges after SDA rises while SCL is high. An SDA change while SCL is low has no effect on it.
- R5: A start request on a free bus puts the block in master mode two edges after the write, with SDA pulled low and SCL released. SCL then stays high for half_period+1 cycles before it is pulled low. Once the START is complete, bit 5 returns to 0 and the block holds SCL low.
- R6: A start request while the bus is busy takes master mode but drives nothing. After a STOP on the bus, SDA is pulled for the START no earlier than one half period after `bus_busy` falls.
- R7: A stop request while the block owns the bus produces a STOP, with SCL released half_period+1 cycles before SDA. Bit 4 then clears after the STOP is seen on the bus, and the block drops to slave mode.
- R8: A start request while the block owns the bus produces a repeated START: SDA is released, SCL is released, then SDA falls. No STOP is seen and `bus_busy` stays 1.
- R9: Start and stop requests together while the block owns the bus produce a STOP followed by a START. Both bits end at 0 and the block ends in master mode holding the bus.
- R10: A stop request in slave mode (including a master waiting for the bus) pulses `int_stop` for one cycle, clears bit 4 on the next edge and drives neither line.
- R11: While bit 5 is 0, no START is produced. Clearing bit 5 while the block waits for the bus returns it to slave mode on the next edge.
- R12: Clearing bit 6 releases both lines and leaves master mode on the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| set_we | input | 1 | Set-port write strobe |
| set_data | input | 8 | Bits to raise in the control byte |
| clr_we | input | 1 | Clear-port write strobe |
| clr_data | input | 8 | Bits to lower in the control byte |
| half_period | input | 16 | Half bus period in clock cycles |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ctrl_q | output | 8 | Control byte |
| is_master | output | 1 | Block is in master mode |
| bus_busy | output | 1 | A START has been seen and no STOP since |
| int_stop | output | 1 | One-cycle internal stop pulse in slave mode |

## Verification
Each write changes `ctrl_q` on the first edge, and the next-state and line-drive outputs follow on the second edge. `bus_busy` trails a line change by three edges: two synchroniser stages plus the edge register. Timed phases last half_period+1 cycles. The bench drives at falling clock edges and samples at falling edges exactly that many cycles later. Where several phases chain, such as a START after a foreign STOP or a STOP followed by a START, it counts cycles until an event and checks the count against a window derived from these latencies. It does not check a single cycle there.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int CTRL_W  = 8;
    localparam int BIT_ACK = 2;
    localparam int BIT_IRQ = 3;
    localparam int BIT_STO = 4;
    localparam int BIT_STA = 5;
    localparam int BIT_EN  = 6;

    localparam logic [CTRL_W-1:0] SET_MASK = (CTRL_W'(1) << BIT_ACK) | (CTRL_W'(1) << BIT_IRQ)
                                           | (CTRL_W'(1) << BIT_STO) | (CTRL_W'(1) << BIT_STA)
                                           | (CTRL_W'(1) << BIT_EN);
    localparam logic [CTRL_W-1:0] CLR_MASK = SET_MASK & ~(CTRL_W'(1) << BIT_STO);

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_GAP,
        SQ_STA_A,
        SQ_STA_B,
        SQ_HOLD,
        SQ_RS_A,
        SQ_RS_B,
        SQ_STO_A,
        SQ_STO_B,
        SQ_STO_C
    } seq_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } pin_drive_t;

    function automatic pin_drive_t drive_of(seq_state_e s);
        pin_drive_t d;
        d = '0;
        case (s)
            SQ_STA_A: d.sda = 1'b1;
            SQ_STA_B: begin d.scl = 1'b1; d.sda = 1'b1; end
            SQ_HOLD:  begin d.scl = 1'b1; d.sda = 1'b1; end
            SQ_RS_A:  d.scl = 1'b1;
            SQ_STO_A: begin d.scl = 1'b1; d.sda = 1'b1; end
            SQ_STO_B: d.sda = 1'b1;
            default:  d = '0;
        endcase
        return d;
    endfunction

    function automatic logic master_of(seq_state_e s);
        return s != SQ_IDLE;
    endfunction

endpackage

// File: rtl/i2c_cond_busmon.sv
module i2c_cond_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_s, sda_s, scl_p, sda_p;
    logic start_det, stop_det;
    logic busy_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_in;
                    sda_sync <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    assign start_det = scl_s && scl_p && sda_p && !sda_s;
    assign stop_det  = scl_s && scl_p && !sda_p && sda_s;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
            if (start_det)
                busy_q <= 1'b1;
            else if (stop_det)
                busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;

    // R4: the bus is released by the monitor only while SCL was high
    assert_busy_falls_scl_high_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_q) && $past(en)) |-> $past(scl_s));

endmodule

// File: rtl/i2c_cond_timer.sv
module i2c_cond_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sta,
    input  logic sto,
    input  logic bus_busy,
    input  logic expired,
    output logic restart,
    output logic drv_scl,
    output logic drv_sda,
    output logic master,
    output logic sta_done,
    output logic sto_done,
    output logic int_stop
);
    seq_state_e state_q, state_d;
    pin_drive_t drv;

    always_comb begin
        state_d  = state_q;
        sta_done = 1'b0;
        sto_done = 1'b0;
        int_stop = 1'b0;
        case (state_q)
            SQ_IDLE: begin
                if (sto) begin
                    int_stop = 1'b1;
                    sto_done = 1'b1;
                end
                if (sta)
                    state_d = bus_busy ? SQ_WAIT : SQ_STA_A;
            end
            SQ_WAIT: begin
                if (sto) begin
                    int_stop = 1'b1;
                    sto_done = 1'b1;
                end
                if (!sta)
                    state_d = SQ_IDLE;
                else if (!bus_busy)
                    state_d = SQ_GAP;
            end
            SQ_GAP: begin
                if (sto) begin
                    int_stop = 1'b1;
                    sto_done = 1'b1;
                end
                if (!sta)
                    state_d = SQ_IDLE;
                else if (bus_busy)
                    state_d = SQ_WAIT;
                else if (expired)
                    state_d = SQ_STA_A;
            end
            SQ_STA_A: if (expired) state_d = SQ_STA_B;
            SQ_STA_B: begin
                if (expired) begin
                    state_d  = SQ_HOLD;
                    sta_done = 1'b1;
                end
            end
            SQ_HOLD: begin
                if (sto)
                    state_d = SQ_STO_A;
                else if (sta)
                    state_d = SQ_RS_A;
            end
            SQ_RS_A:  if (expired) state_d = SQ_RS_B;
            SQ_RS_B:  if (expired) state_d = SQ_STA_A;
            SQ_STO_A: if (expired) state_d = SQ_STO_B;
            SQ_STO_B: if (expired) state_d = SQ_STO_C;
            SQ_STO_C: begin
                if (expired && !bus_busy) begin
                    sto_done = 1'b1;
                    state_d  = sta ? SQ_GAP : SQ_IDLE;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            state_q <= SQ_IDLE;
        else
            state_q <= state_d;
    end

    assign restart = (state_d != state_q);
    assign drv     = drive_of(state_q);
    assign drv_scl = drv.scl;
    assign drv_sda = drv.sda;
    assign master  = master_of(state_q);

    // R5: SCL is only pulled during a START after SDA has already been pulled
    assert_sda_before_scl_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_STA_B) |-> $past(drv_sda));

    // R7: a STOP releases SDA only after SCL was already released
    assert_stop_order_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_STO_C && $past(state_q) == SQ_STO_B) |-> ($past(drv_sda) && !$past(drv_scl)));

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
    import i2c_cond_pkg::*;
#(
    parameter int HP_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic [CTRL_W-1:0] set_data,
    input  logic              clr_we,
    input  logic [CTRL_W-1:0] clr_data,
    input  logic [HP_W-1:0]   half_period,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              is_master,
    output logic              bus_busy,
    output logic              int_stop
);
    logic [CTRL_W-1:0] ctrl_r, ctrl_d, seq_clr;
    logic en;
    logic busy;
    logic tmr_restart, tmr_expired;
    logic drv_scl, drv_sda, master, sta_done, sto_done, stop_pulse;

    assign en = ctrl_r[BIT_EN];

    always_comb begin
        seq_clr          = '0;
        seq_clr[BIT_STA] = sta_done;
        seq_clr[BIT_STO] = sto_done;
        ctrl_d = ctrl_r & ~seq_clr;
        if (set_we)
            ctrl_d = ctrl_d | (set_data & SET_MASK);
        if (clr_we)
            ctrl_d = ctrl_d & ~(clr_data & CLR_MASK);
        if (!ctrl_d[BIT_EN])
            ctrl_d[BIT_STO] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_r <= '0;
        else
            ctrl_r <= ctrl_d;
    end

    i2c_cond_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .busy   (busy)
    );

    i2c_cond_timer #(.CNT_W(HP_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .limit   (half_period),
        .expired (tmr_expired)
    );

    i2c_cond_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sta      (ctrl_r[BIT_STA]),
        .sto      (ctrl_r[BIT_STO]),
        .bus_busy (busy),
        .expired  (tmr_expired),
        .restart  (tmr_restart),
        .drv_scl  (drv_scl),
        .drv_sda  (drv_sda),
        .master   (master),
        .sta_done (sta_done),
        .sto_done (sto_done),
        .int_stop (stop_pulse)
    );

    assign ctrl_q    = ctrl_r;
    assign scl_oe    = drv_scl && en;
    assign sda_oe    = drv_sda && en;
    assign is_master = master && en;
    assign bus_busy  = busy;
    assign int_stop  = stop_pulse && en;

    // R3: the stop request never survives while the interface is off
    assert_sto_off_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_r[BIT_EN] |-> !ctrl_r[BIT_STO]);

    // R1: a set of the acknowledge flag without a clear takes effect next edge
    assert_set_takes_R1: assert property (@(posedge clk) disable iff (rst)
        $past(set_we && set_data[BIT_ACK] && !(clr_we && clr_data[BIT_ACK])) |-> ctrl_r[BIT_ACK]);

    // R2: a clear of the enable wins over any set in the same cycle
    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
        $past(clr_we && clr_data[BIT_EN]) |-> !ctrl_r[BIT_EN]);

endmodule

// File: tb/sim_i2c_cond_ctrl.sv
module sim_i2c_cond_ctrl;
    localparam int HP = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       set_we = 1'b0, clr_we = 1'b0;
    logic [7:0] set_data = '0, clr_data = '0;
    logic [15:0] half_period = 16'(HP);
    logic       ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic       scl_oe, sda_oe, is_master, bus_busy, int_stop;
    logic [7:0] ctrl_q;
    wire        scl_line = !scl_oe && !ext_scl_low;
    wire        sda_line = !sda_oe && !ext_sda_low;

    int n_chk = 0, n_fail = 0;
    int n_start, n_stop, first_start_at, first_stop_at, stop_gap, scl_rise_at;
    bit drove, busy_low;

    always #2 clk = ~clk;

    i2c_cond_ctrl u0 (
        .clk(clk), .rst(rst), .set_we(set_we), .set_data(set_data),
        .clr_we(clr_we), .clr_data(clr_data), .half_period(half_period),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .ctrl_q(ctrl_q), .is_master(is_master), .bus_busy(bus_busy), .int_stop(int_stop)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_set(input logic [7:0] d);
        set_we = 1'b1; set_data = d; step(1); set_we = 1'b0; set_data = '0;
    endtask

    task automatic wr_clr(input logic [7:0] d);
        clr_we = 1'b1; clr_data = d; step(1); clr_we = 1'b0; clr_data = '0;
    endtask

    task automatic wr_both(input logic [7:0] s, input logic [7:0] c);
        set_we = 1'b1; set_data = s; clr_we = 1'b1; clr_data = c; step(1);
        set_we = 1'b0; set_data = '0; clr_we = 1'b0; clr_data = '0;
    endtask

    task automatic observe(input int n);
        bit ps, pd;
        ps = scl_line; pd = sda_line;
        n_start = 0; n_stop = 0; first_start_at = -1; first_stop_at = -1;
        stop_gap = -1; scl_rise_at = 0; drove = 0; busy_low = 0;
        for (int i = 1; i <= n; i++) begin
            step(1);
            if (scl_oe || sda_oe) drove = 1;
            if (!bus_busy) busy_low = 1;
            if (ps && scl_line && pd && !sda_line) begin
                n_start++;
                if (first_start_at < 0) first_start_at = i;
            end
            if (ps && scl_line && !pd && sda_line) begin
                n_stop++;
                if (first_stop_at < 0) first_stop_at = i;
                stop_gap = i - scl_rise_at;
            end
            if (!ps && scl_line) scl_rise_at = i;
            ps = scl_line; pd = sda_line;
        end
    endtask

    task automatic wait_sta_clear();
        for (int c = 0; c < 100 && ctrl_q[5]; c++) step(1);
    endtask

    task automatic t_reset();
        eq("R1", "reset ctrl_q", ctrl_q, 0);
        eq("R1", "reset scl_oe", scl_oe, 0);
        eq("R1", "reset sda_oe", sda_oe, 0);
        eq("R1", "reset is_master", is_master, 0);
        eq("R4", "reset bus_busy", bus_busy, 0);
    endtask

    task automatic t_regs();
        wr_set(8'h44);   eq("R1", "set enable+ack", ctrl_q, 8'h44);
        wr_set(8'h00);   eq("R1", "zero set no effect", ctrl_q, 8'h44);
        wr_set(8'h83);   eq("R1", "reserved bits read 0", ctrl_q, 8'h44);
        wr_set(8'h08);   eq("R1", "set irq flag", ctrl_q, 8'h4C);
        wr_clr(8'h08);   eq("R2", "clear irq flag", ctrl_q, 8'h44);
        wr_both(8'h04, 8'h04); eq("R2", "clear wins over set", ctrl_q, 8'h40);
    endtask

    task automatic t_busmon();
        ext_sda_low = 1'b1; step(2);
        eq("R4", "busy not yet after 2 edges", bus_busy, 0);
        step(1);
        eq("R4", "busy after START +3 edges", bus_busy, 1);
        ext_sda_low = 1'b0; step(3);
        eq("R4", "free after STOP +3 edges", bus_busy, 0);
        ext_scl_low = 1'b1; step(1);
        ext_sda_low = 1'b1; step(1);
        ext_scl_low = 1'b0; step(5);
        eq("R4", "SDA fall with SCL low ignored", bus_busy, 0);
        ext_sda_low = 1'b0; step(4);
    endtask

    task automatic t_no_sta();
        observe(30);
        eq("R11", "no drive without start request", drove, 0);
        eq("R11", "slave without start request", is_master, 0);
        eq("R11", "no START without start request", n_start, 0);
    endtask

    task automatic t_start_free();
        int c;
        wr_set(8'h20); step(1);
        eq("R5", "master two edges after write", is_master, 1);
        eq("R5", "SDA low in START", sda_line, 0);
        eq("R5", "SCL high in START", scl_line, 1);
        c = 0;
        while (scl_line && c < 100) begin step(1); c++; end
        chk(c >= HP && c <= HP + 2, "R5", "SCL high span after SDA fall", c, HP + 1);
        wait_sta_clear();
        eq("R5", "start flag self-clears", ctrl_q[5], 0);
        eq("R5", "master holds bus", is_master, 1);
        eq("R5", "SCL held low", scl_line, 0);
        eq("R5", "own START seen busy", bus_busy, 1);
    endtask

    task automatic t_repeat();
        wr_set(8'h20); observe(60);
        eq("R8", "one repeated START", n_start, 1);
        eq("R8", "no STOP in repeated START", n_stop, 0);
        eq("R8", "busy held throughout", busy_low, 0);
        eq("R8", "start flag cleared", ctrl_q[5], 0);
        eq("R8", "still master", is_master, 1);
    endtask

    task automatic t_stop();
        wr_set(8'h10); observe(60);
        eq("R7", "one STOP", n_stop, 1);
        eq("R7", "no START", n_start, 0);
        chk(stop_gap >= HP, "R7", "SCL high before SDA rise", stop_gap, HP + 1);
        eq("R7", "stop flag cleared", ctrl_q[4], 0);
        eq("R7", "back to slave", is_master, 0);
        eq("R7", "bus free", bus_busy, 0);
        eq("R7", "lines released", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_stop_start();
        wr_set(8'h20); observe(40);
        eq("R9", "prep START done", ctrl_q[5], 0);
        wr_set(8'h30); observe(100);
        eq("R9", "STOP count", n_stop, 1);
        eq("R9", "START count", n_start, 1);
        chk(first_stop_at < first_start_at, "R9", "STOP before START", first_stop_at, first_start_at);
        eq("R9", "both flags cleared", ctrl_q[5:4], 0);
        eq("R9", "master after STOP+START", is_master, 1);
        eq("R9", "bus busy after START", bus_busy, 1);
        wr_set(8'h10); observe(60);
        eq("R7", "release after STOP", is_master, 0);
    endtask

    task automatic t_wait_busy();
        int c;
        ext_sda_low = 1'b1; step(4);
        eq("R6", "foreign START busy", bus_busy, 1);
        wr_set(8'h20); observe(30);
        eq("R6", "no drive while busy", drove, 0);
        eq("R6", "master while waiting", is_master, 1);
        ext_sda_low = 1'b0;
        c = 0;
        while (!sda_oe && c < 100) begin step(1); c++; end
        chk(c >= HP + 1 && c <= HP + 8, "R6", "START delay after foreign STOP", c, HP + 5);
        eq("R6", "SCL high at START", scl_line, 1);
        wait_sta_clear();
        eq("R6", "owns bus after delayed START", is_master, 1);
        wr_set(8'h10); observe(60);
        eq("R7", "release after delayed START", is_master, 0);
    endtask

    task automatic t_slave_stop();
        wr_set(8'h10);
        eq("R10", "internal stop pulse", int_stop, 1);
        step(1);
        eq("R10", "pulse one cycle", int_stop, 0);
        eq("R10", "stop flag cleared", ctrl_q[4], 0);
        eq("R10", "no drive for slave stop", {scl_oe, sda_oe}, 0);
        eq("R10", "stays slave", is_master, 0);
        ext_sda_low = 1'b1; step(4);
        wr_set(8'h30);
        eq("R10", "internal stop with start", int_stop, 1);
        step(1);
        eq("R10", "stop flag cleared (both)", ctrl_q[4], 0);
        eq("R10", "waiting master", is_master, 1);
        eq("R10", "no drive while waiting", {scl_oe, sda_oe}, 0);
        wr_clr(8'h20); step(1);
        eq("R11", "cancel returns to slave", is_master, 0);
        observe(10);
        eq("R11", "no drive after cancel", drove, 0);
        ext_sda_low = 1'b0; step(4);
    endtask

    task automatic t_disable();
        wr_set(8'h20); wait_sta_clear();
        eq("R12", "owning before disable", is_master, 1);
        wr_clr(8'h40);
        eq("R12", "lines released on disable", {scl_oe, sda_oe}, 0);
        eq("R12", "slave on disable", is_master, 0);
        eq("R12", "enable bit low", ctrl_q[6], 0);
        step(1);
        eq("R12", "monitor cleared", bus_busy, 0);
    endtask

    task automatic t_disabled();
        wr_set(8'h10);
        eq("R3", "stop flag held low when off", ctrl_q, 0);
        ext_sda_low = 1'b1; step(6);
        eq("R3", "lines ignored when off", bus_busy, 0);
        ext_sda_low = 1'b0;
        wr_set(8'h20); step(3);
        eq("R3", "start flag stored", ctrl_q, 8'h20);
        eq("R3", "slave when off", is_master, 0);
        eq("R3", "no drive when off", {scl_oe, sda_oe}, 0);
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        t_reset();
        t_regs();
        t_busmon();
        t_no_sta();
        t_start_free();
        t_repeat();
        t_stop();
        t_stop_start();
        t_wait_busy();
        t_slave_stop();
        t_disable();
        t_disabled();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule